// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM by driving the chip-select, serial-clock and data-to-memory pins directly and sampling the memory's data-out pin. A single read is started with a one-cycle request that carries a 6-bit word address. The block then runs the full pin sequence and returns the word with a one-cycle completion pulse. The length of each clock phase comes from a programmable half-period input, so one design can suit memories of different speeds.

A second entry point reads the whole memory: all 64 words, stored little-endian into a 128-byte buffer that the surrounding logic reads through an index port. When the dump ends, the block looks at the first two bytes to decide whether a memory is fitted at all. If one is, it takes a 6-byte node address from bytes 20 to 25 of the buffer.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, select, clock and data-to-memory are low, `rd_busy`, `rd_done` and `dump_done` are low, `rom_absent` is low and `node_addr` is zero.
- R2: Every access first holds select low for one phase. It then raises select while the clock is low and keeps it so for one phase before the first clock rise.
- R3: The first nine bits sent on the data-to-memory pin are the opcode 1, 1, 0 (in that order) and then the word address, most significant bit first.
- R4: Each bit sent is held through a low phase, a high phase and a second low phase of the clock. The data pin does not change while the clock is high, and the clock is high only while select is high.
- R5: After one phase with the clock low, sixteen bits are captured from the memory, one near the end of each clock-high phase and most significant first. Select then drops for one phase and `rd_done` pulses for exactly one cycle with the word on `rd_data`. Select is low during that pulse.
- R6: Every clock phase lasts `half_period` system clocks, and values 0 and 1 are treated as 2.
- R7: `rd_req` and `dump_start` are ignored while `rd_busy` is high, so a request made during an access starts no second access. `rd_busy` is low in the cycle of `rd_done`.
- R8: A dump reads words 0 to 63 in order, and `buf_byte` for index 2k returns bits 7:0 of word k while index 2k+1 returns bits 15:8.
- R9: At the end of a dump, `rom_absent` is set exactly when buffer bytes 0 and 1 are both 0xFF or both 0x00. A mixed pair such as 0xFF, 0x00 counts as present.
- R10: At the end of a dump, `node_addr[8i+7:8i]` equals buffer byte 20+i for i = 0 to 5, or zero when `rom_absent` is set.
- R11: A dump ends with a one-cycle `dump_done` pulse, and `rd_done` does not pulse for the words read during a dump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | 8 | System clocks per serial clock phase (minimum 2) |
| rd_req | input | 1 | One-cycle request for a single word read |
| rd_addr | input | 6 | Word address of the request |
| rd_busy | output | 1 | An access or dump is in progress |
| rd_data | output | 16 | Last word read |
| rd_done | output | 1 | One-cycle pulse when a single read completes |
| dump_start | input | 1 | One-cycle request to read the whole memory |
| dump_done | output | 1 | One-cycle pulse when the dump and its checks complete |
| rom_absent | output | 1 | Memory judged not fitted after the last dump |
| node_addr | output | 48 | Node address taken from the buffer, byte 0 in bits 7:0 |
| buf_idx | input | 7 | Byte index into the dump buffer |
| buf_byte | output | 8 | Buffer byte at `buf_idx` |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Data from this block to the memory |
| ee_do | input | 1 | Data from the memory to this block |

## Verification
The hardest case to reach from the ports is the absence decision. It depends only on the bytes stored at buffer positions 0 and 1, which come from a full 64-word transfer. The bench therefore models the memory itself: it decodes the opcode and address from the pins and answers with contents it controls. Before each of several dumps it loads word 0 with all ones, all zeros, or a mixed pattern. The effective clock phase floor is reached by running reads with half-period values of 0 and 1. The bench then measures the high time it observes on the clock pin.

// File: rtl/srom_pkg.sv
package srom_pkg;

    // Read command bits, sent leftmost first
    localparam logic [2:0] SROM_OP_READ = 3'b110;
    localparam int         SROM_OP_W    = 3;
    localparam int         SROM_MIN_HALF = 2;

    typedef enum logic [3:0] {
        ENG_IDLE,
        ENG_PRE,     // select low for one phase
        ENG_SEL,     // select high, clock low
        ENG_WLO,     // bit presented, clock low
        ENG_WHI,     // bit held, clock high
        ENG_WLO2,    // bit held, clock low again
        ENG_GAP,     // turnaround, clock low
        ENG_RHI,     // clock high, capture at its end
        ENG_RLO,     // clock low
        ENG_END      // select low
    } eng_state_e;

    typedef enum logic [1:0] {
        DMP_IDLE,
        DMP_ISSUE,
        DMP_WAIT,
        DMP_FINISH
    } dump_state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } srom_pins_t;

    // A blank or unfitted part reads all ones or all zeros in its first two bytes
    function automatic logic srom_is_blank(input logic [7:0] b0, input logic [7:0] b1);
        return ((b0 == 8'hFF) && (b1 == 8'hFF)) || ((b0 == 8'h00) && (b1 == 8'h00));
    endfunction

endpackage

// File: rtl/srom_phase_timer.sv
module srom_phase_timer
    import srom_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_half;

    assign eff_half = (half_period < DIV_W'(SROM_MIN_HALF)) ? DIV_W'(SROM_MIN_HALF) : half_period;
    assign tick     = en && (cnt_q >= eff_half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/srom_word_engine.sv
module srom_word_engine
    import srom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output srom_pins_t        pins
);
    localparam int CMD_W = SROM_OP_W + ADDR_W;
    localparam int CNT_W = $clog2(CMD_W + DATA_W);

    eng_state_e        state_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  bit_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cmd_q   <= '0;
            data_q  <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ENG_IDLE: if (start) begin
                    cmd_q   <= {SROM_OP_READ, addr};
                    bit_q   <= '0;
                    state_q <= ENG_PRE;
                end
                ENG_PRE:  if (tick) state_q <= ENG_SEL;
                ENG_SEL:  if (tick) state_q <= ENG_WLO;
                ENG_WLO:  if (tick) state_q <= ENG_WHI;
                ENG_WHI:  if (tick) state_q <= ENG_WLO2;
                ENG_WLO2: if (tick) begin
                    cmd_q <= cmd_q << 1;
                    if (bit_q == CNT_W'(CMD_W - 1)) begin
                        bit_q   <= '0;
                        state_q <= ENG_GAP;
                    end else begin
                        bit_q   <= bit_q + CNT_W'(1);
                        state_q <= ENG_WLO;
                    end
                end
                ENG_GAP:  if (tick) state_q <= ENG_RHI;
                ENG_RHI:  if (tick) begin
                    data_q  <= {data_q[DATA_W-2:0], ee_do};
                    state_q <= ENG_RLO;
                end
                ENG_RLO:  if (tick) begin
                    if (bit_q == CNT_W'(DATA_W - 1)) begin
                        state_q <= ENG_END;
                    end else begin
                        bit_q   <= bit_q + CNT_W'(1);
                        state_q <= ENG_RHI;
                    end
                end
                ENG_END:  if (tick) begin
                    state_q <= ENG_IDLE;
                    done_q  <= 1'b1;
                end
                default:  state_q <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.cs = !(state_q inside {ENG_IDLE, ENG_PRE, ENG_END});
        pins.sk = (state_q == ENG_WHI) || (state_q == ENG_RHI);
        pins.di = (state_q inside {ENG_WLO, ENG_WHI, ENG_WLO2}) ? cmd_q[CMD_W-1] : 1'b0;
    end

    assign busy = (state_q != ENG_IDLE);
    assign done = done_q;
    assign data = data_q;
endmodule

// File: rtl/srom_dump_ctrl.sv
module srom_dump_ctrl
    import srom_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int NODE_OFS = 20,
    parameter int NODE_LEN = 6,
    localparam int WORDS   = 1 << ADDR_W,
    localparam int BPW     = DATA_W / 8,
    localparam int BYTES   = WORDS * BPW,
    localparam int IDX_W   = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  eng_done,
    input  logic [DATA_W-1:0]     eng_data,
    output logic                  go,
    output logic [ADDR_W-1:0]     addr,
    output logic                  active,
    output logic                  done,
    output logic                  absent,
    output logic [8*NODE_LEN-1:0] node,
    input  logic [IDX_W-1:0]      buf_idx,
    output logic [7:0]            buf_byte
);
    dump_state_e           state_q;
    logic [ADDR_W-1:0]     widx_q;
    logic [7:0]            mem_q [BYTES];
    logic                  done_q;
    logic                  absent_q;
    logic [8*NODE_LEN-1:0] node_q;
    logic                  blank;

    assign blank = srom_is_blank(mem_q[0], mem_q[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= DMP_IDLE;
            widx_q   <= '0;
            done_q   <= 1'b0;
            absent_q <= 1'b0;
            node_q   <= '0;
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'h00;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DMP_IDLE: if (start) begin
                    widx_q  <= '0;
                    state_q <= DMP_ISSUE;
                end
                DMP_ISSUE: state_q <= DMP_WAIT;
                DMP_WAIT: if (eng_done) begin
                    for (int b = 0; b < BPW; b++)
                        mem_q[IDX_W'(int'(widx_q) * BPW + b)] <= eng_data[8*b +: 8];
                    if (widx_q == ADDR_W'(WORDS - 1)) begin
                        state_q <= DMP_FINISH;
                    end else begin
                        widx_q  <= widx_q + ADDR_W'(1);
                        state_q <= DMP_ISSUE;
                    end
                end
                DMP_FINISH: begin
                    absent_q <= blank;
                    for (int i = 0; i < NODE_LEN; i++)
                        node_q[8*i +: 8] <= blank ? 8'h00 : mem_q[NODE_OFS + i];
                    done_q  <= 1'b1;
                    state_q <= DMP_IDLE;
                end
                default: state_q <= DMP_IDLE;
            endcase
        end
    end

    assign go       = (state_q == DMP_ISSUE);
    assign addr     = widx_q;
    assign active   = (state_q != DMP_IDLE);
    assign done     = done_q;
    assign absent   = absent_q;
    assign node     = node_q;
    assign buf_byte = mem_q[buf_idx];
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
    import srom_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int DIV_W    = 8,
    parameter int NODE_OFS = 20,
    parameter int NODE_LEN = 6
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [DIV_W-1:0]                          half_period,
    input  logic                                      rd_req,
    input  logic [ADDR_W-1:0]                         rd_addr,
    output logic                                      rd_busy,
    output logic [DATA_W-1:0]                         rd_data,
    output logic                                      rd_done,
    input  logic                                      dump_start,
    output logic                                      dump_done,
    output logic                                      rom_absent,
    output logic [8*NODE_LEN-1:0]                     node_addr,
    input  logic [$clog2((1<<ADDR_W)*DATA_W/8)-1:0]   buf_idx,
    output logic [7:0]                                buf_byte,
    output logic                                      ee_cs,
    output logic                                      ee_sk,
    output logic                                      ee_di,
    input  logic                                      ee_do
);
    logic              tick;
    logic              eng_start;
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_data;
    srom_pins_t        pins;
    logic              dmp_go;
    logic [ADDR_W-1:0] dmp_addr;
    logic              dmp_active;
    logic              dmp_start_ok;
    logic              ext_go;

    assign rd_busy      = eng_busy || dmp_active;
    assign dmp_start_ok = dump_start && !rd_busy;
    assign ext_go       = rd_req && !rd_busy && !dump_start;
    assign eng_start    = ext_go || dmp_go;
    assign eng_addr     = dmp_active ? dmp_addr : rd_addr;

    srom_phase_timer #(.DIV_W(DIV_W)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .en          (eng_busy),
        .half_period (half_period),
        .tick        (tick)
    );

    srom_word_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (eng_start),
        .addr  (eng_addr),
        .ee_do (ee_do),
        .busy  (eng_busy),
        .done  (eng_done),
        .data  (eng_data),
        .pins  (pins)
    );

    srom_dump_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NODE_OFS(NODE_OFS), .NODE_LEN(NODE_LEN)
    ) i_dump (
        .clk      (clk),
        .rst      (rst),
        .start    (dmp_start_ok),
        .eng_done (eng_done),
        .eng_data (eng_data),
        .go       (dmp_go),
        .addr     (dmp_addr),
        .active   (dmp_active),
        .done     (dump_done),
        .absent   (rom_absent),
        .node     (node_addr),
        .buf_idx  (buf_idx),
        .buf_byte (buf_byte)
    );

    assign rd_data = eng_data;
    assign rd_done = eng_done && !dmp_active;
    assign ee_cs   = pins.cs;
    assign ee_sk   = pins.sk;
    assign ee_di   = pins.di;
endmodule

// File: rtl/serial_rom_reader_chk.sv
module serial_rom_reader_chk (
    input logic clk,
    input logic rst,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di,
    input logic rd_busy,
    input logic rd_done,
    input logic dump_done,
    input logic rom_absent,
    input logic node_is_zero
);
    assert_select_rises_clock_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_cs) |-> !ee_sk);

    assert_clock_needs_select_R4: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    assert_data_steady_while_high_R4: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    assert_done_deselected_R5: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !ee_cs);

    assert_high_phase_floor_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sk) |=> ee_sk);

    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !rd_busy);

    assert_blank_clears_node_R10: assert property (@(posedge clk) disable iff (rst)
        rom_absent |-> node_is_zero);

    assert_dump_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        dump_done |=> !dump_done);

    assert_no_word_pulse_on_dump_end_R11: assert property (@(posedge clk) disable iff (rst)
        dump_done |-> !rd_done);
endmodule

bind serial_rom_reader serial_rom_reader_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .ee_cs        (ee_cs),
    .ee_sk        (ee_sk),
    .ee_di        (ee_di),
    .rd_busy      (rd_busy),
    .rd_done      (rd_done),
    .dump_done    (dump_done),
    .rom_absent   (rom_absent),
    .node_is_zero (node_addr == '0)
);

// File: tb/test_serial_rom_reader.sv
`timescale 1ns/1ps
module test_serial_rom_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  half_period = 8'd2;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        rd_busy;
    logic [15:0] rd_data;
    logic        rd_done;
    logic        dump_start = 1'b0;
    logic        dump_done;
    logic        rom_absent;
    logic [47:0] node_addr;
    logic [6:0]  buf_idx = '0;
    logic [7:0]  buf_byte;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    serial_rom_reader i_serial_rom_reader (
        .clk(clk), .rst(rst), .half_period(half_period),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_busy(rd_busy),
        .rd_data(rd_data), .rd_done(rd_done),
        .dump_start(dump_start), .dump_done(dump_done),
        .rom_absent(rom_absent), .node_addr(node_addr),
        .buf_idx(buf_idx), .buf_byte(buf_byte),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // Memory model: decodes the pins, answers with rom contents
    logic [15:0] rom [64];
    int          nb = 0, frames = 0, bad = 0, hi_run = 0, last_hi = 0;
    logic [8:0]  cmd = '0;
    logic [5:0]  last_addr = '0;
    logic        p_cs = 1'b0, p_sk = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            p_cs = 1'b0; p_sk = 1'b0; hi_run = 0; nb = 0;
        end else begin
            if (ee_cs && !p_cs) begin
                if (ee_sk) bad++;
                nb = 0;
            end
            if (!ee_cs && p_cs) begin
                frames++;
                if (nb != 25) bad++;
            end
            if (ee_sk && !p_sk) begin
                if (!ee_cs) bad++;
                nb++;
                if (nb <= 9) cmd = {cmd[7:0], ee_di};
                if (nb == 9) begin
                    last_addr = cmd[5:0];
                    if (cmd[8:6] != 3'b110) bad++;
                end
                if (nb >= 10 && nb <= 25) ee_do <= rom[last_addr][25 - nb];
            end
            if (ee_sk) hi_run++;
            else if (p_sk) begin last_hi = hi_run; hi_run = 0; end
            p_cs = ee_cs; p_sk = ee_sk;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_half(input int h);
        return (h < 2) ? 2 : h;
    endfunction

    function automatic logic [7:0] exp_byte(input int k);
        return k[0] ? rom[k/2][15:8] : rom[k/2][7:0];
    endfunction

    function automatic bit exp_blank();
        return (rom[0] == 16'hFFFF) || (rom[0] == 16'h0000);
    endfunction

    function automatic logic [47:0] exp_node();
        logic [47:0] n = '0;
        if (!exp_blank())
            for (int i = 0; i < 6; i++) n[8*i +: 8] = exp_byte(20 + i);
        return n;
    endfunction

    task automatic do_read(input logic [5:0] a, output logic [15:0] d);
        while (rd_busy) @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        while (!rd_done) @(negedge clk);
        d = rd_data;
    endtask

    task automatic do_dump(output int word_pulses);
        word_pulses = 0;
        while (rd_busy) @(negedge clk);
        dump_start = 1'b1;
        @(negedge clk);
        dump_start = 1'b0;
        while (!dump_done) begin
            if (rd_done) word_pulses++;
            @(negedge clk);
        end
    endtask

    task automatic run_dump(input string tag);
        int pulses, f0;
        f0 = frames;
        do_dump(pulses);
        @(negedge clk);
        check(frames - f0 == 64, {"R8 dump frame count ", tag}, frames - f0, 64);
        check(pulses == 0, {"R11 rd_done during dump ", tag}, pulses, 0);
        check(bad == 0, {"R3 protocol errors in dump ", tag}, bad, 0);
        check(rom_absent == exp_blank(), {"R9 absent flag ", tag}, rom_absent, exp_blank());
        check(node_addr == exp_node(), {"R10 node address ", tag}, node_addr, exp_node());
        for (int k = 0; k < 128; k++) begin
            buf_idx = 7'(k);
            #1;
            check(buf_byte == exp_byte(k), {"R8 buffer byte ", tag}, buf_byte, exp_byte(k));
        end
    endtask

    initial begin
        int unused_seed;
        logic [15:0] d;
        logic [5:0]  a, b;
        int          f0;
        int          hs [5] = '{0, 1, 2, 3, 7};
        unused_seed = $urandom(32'd2024);
        for (int i = 0; i < 64; i++) rom[i] = 16'($urandom);
        rom[0] = 16'hA55A;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins low", {ee_cs, ee_sk, ee_di}, 0);
        check({rd_busy, rd_done, dump_done} == 3'b000, "R1 status low", {rd_busy, rd_done, dump_done}, 0);
        check(rom_absent == 1'b0 && node_addr == '0, "R1 absent and node clear", node_addr, 0);

        // R3 R5 R6: reads at several phase lengths, including the floor
        foreach (hs[j]) begin
            half_period = 8'(hs[j]);
            a = 6'($urandom);
            do_read(a, d);
            check(d == rom[a], "R5 read word", d, rom[a]);
            check(last_addr == a, "R3 address sent", last_addr, a);
            check(bad == 0, "R2 R4 frame shape", bad, 0);
            check(last_hi == eff_half(hs[j]), "R6 clock high length", last_hi, eff_half(hs[j]));
        end

        // R5: random addresses, corner addresses 0 and 63
        half_period = 8'd2;
        for (int i = 0; i < 10; i++) begin
            a = (i == 0) ? 6'd0 : (i == 1) ? 6'd63 : 6'($urandom);
            do_read(a, d);
            check(d == rom[a], "R5 random read", d, rom[a]);
            check(last_addr == a, "R3 random address", last_addr, a);
        end

        // R7: a request during an access is dropped
        a = 6'd13; b = 6'd50;
        f0 = frames;
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_req = 1'b1; rd_addr = b;
        @(negedge clk);
        rd_req = 1'b0;
        while (!rd_done) @(negedge clk);
        check(rd_data == rom[a], "R7 first request served", rd_data, rom[a]);
        check(rd_busy == 1'b0, "R7 idle at done", rd_busy, 0);
        repeat (300) @(negedge clk);
        check(frames - f0 == 1, "R7 no second access", frames - f0, 1);

        // R8 to R11: dumps with present, blank-ones, blank-zeros and mixed first word
        run_dump("present");
        rom[0] = 16'hFFFF;
        run_dump("all ones");
        rom[0] = 16'h0000;
        run_dump("all zeros");
        rom[0] = 16'h00FF;
        run_dump("mixed");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule